// File: doc/BRIEF.md
# Program/Erase Status Register with Sticky Errors

This block keeps the eight-bit status word that a flash program/erase controller reports to the host. It follows the controller through its phases (idle, running, paused) from single-cycle event pulses: operation start, completion, failure, pause acknowledge, resume and locked-block access. From these it keeps a ready flag, two pause flags and four error flags. The error flags are sticky. Only an explicit clear pulse or reset removes them, and while any of them is set a new operation is refused without reaching the engine.

The program-supply level is checked once, when an operation is accepted. A low level refuses the operation and raises both the supply flag and the failure flag for that operation kind. Reads go through a snapshot register. The status word is captured on the cycle the active-low read strobe is first seen low, and that value is held until the strobe returns high, so a read never sees a word that changes while it is in progress.

Top module: `pe_status_unit`

## Requirements
- R1: After reset the read port returns 0x80 (ready, no pause flags, no error flags) and `engine_go` is 0.
- R2: A start pulse in the idle phase, with no error flag set and `vpp_ok` high, makes `engine_go` high for exactly one cycle, on the cycle after the start pulse. Bit 7 then reads 0 until a done or fail pulse returns the block to idle. A start pulse outside the idle phase is ignored.
- R3: A pause acknowledge while running sets bit 7 and also sets bit 6 for an erase or bit 2 for a program. Resume clears that pause bit and bit 7. A pause acknowledge in the idle phase is ignored: bit 7 stays 1 and both pause bits stay 0.
- R4: A fail pulse while running sets bit 5 for an erase or bit 4 for a program, and returns the block to idle. These bits are not cleared by later done pulses or by new operations.
- R5: If `vpp_ok` is low when a start is accepted, bit 3 and the failure bit of the requested kind (5 for erase, 4 for program) are set, and the operation does not start: no `engine_go` and bit 7 stays 1. A change of `vpp_ok` during a running operation has no effect on bit 3.
- R6: A `lock_viol` pulse sets bit 1 in any phase.
- R7: A clear pulse resets bits 1, 3, 4 and 5 and leaves bits 7, 6 and 2 unchanged. If an error is raised in the same cycle as a clear, the raised error stays set.
- R8: A start with any error bit set produces no `engine_go`, leaves the block idle, and leaves all error bits unchanged.
- R9: Bit 0 always reads 0.
- R10: `rd_data` is 0 while `rd_strobe_n` is high. On the first cycle the strobe is seen low, the status word is captured, and `rd_data` shows that value from the next cycle. The value is held while the strobe stays low, even if the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Controller requests a new operation |
| op_is_erase | input | 1 | Kind of the requested operation: 1 erase, 0 program |
| vpp_ok | input | 1 | Program supply is above the lockout level |
| op_done | input | 1 | Running operation finished successfully |
| op_fail | input | 1 | Running operation finished with failure |
| susp_ack | input | 1 | Controller has actually paused the operation |
| resume | input | 1 | Paused operation continues |
| lock_viol | input | 1 | Modify of a protected block was attempted |
| clr_status | input | 1 | Clear the error flags |
| rd_strobe_n | input | 1 | Active-low read strobe |
| rd_data | output | 8 | Snapshot of the status word |
| engine_go | output | 1 | One-cycle pulse that starts the program/erase engine |

## Verification
Two collisions are provoked on purpose. In the first, a clear pulse and a `lock_viol` pulse are driven in the same cycle while an operation is paused. Bit 1 must then survive the clear, and the pause bits must stay untouched. In the second, a done pulse arrives while the read strobe is held low. The snapshot must keep the running-state value until the strobe rises, and a fresh read must then show the idle state. A behavioural model in the bench predicts `rd_data` and `engine_go` on every clock, and directed reads compare the word against constants written out from the requirements.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_PAUSE = 2'd2
    } phase_e;

    localparam int STAT_W = 8;
    localparam int ERR_N  = 4;

    // error bank slots
    localparam int ERR_ERASE = 3;
    localparam int ERR_PROG  = 2;
    localparam int ERR_VPP   = 1;
    localparam int ERR_LOCK  = 0;

    // status word bit positions (host software decodes these)
    localparam int SB_READY = 7;
    localparam int SB_ESUSP = 6;
    localparam int SB_EFAIL = 5;
    localparam int SB_PFAIL = 4;
    localparam int SB_VPP   = 3;
    localparam int SB_PSUSP = 2;
    localparam int SB_LOCK  = 1;
endpackage

// File: rtl/fsr_phase.sv
module fsr_phase
    import fsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   op_start_i,
    input  logic   op_is_erase_i,
    input  logic   vpp_ok_i,
    input  logic   err_any_i,
    input  logic   op_done_i,
    input  logic   op_fail_i,
    input  logic   susp_ack_i,
    input  logic   resume_i,
    output phase_e phase_o,
    output logic   erase_o,
    output logic   engine_go_o,
    output logic   set_erase_fail_o,
    output logic   set_prog_fail_o,
    output logic   set_vpp_o
);
    typedef struct packed {
        phase_e ph;
        logic   erase;
        logic   go;
    } ph_state_t;

    ph_state_t st_d, st_q;
    logic accept, launch, vpp_bad, run_fail;

    always_comb begin
        accept   = op_start_i && (st_q.ph == PH_IDLE);
        launch   = accept && !err_any_i && vpp_ok_i;
        vpp_bad  = accept && !err_any_i && !vpp_ok_i;
        run_fail = (st_q.ph == PH_RUN) && op_fail_i;

        st_d    = st_q;
        st_d.go = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    st_d.ph    = PH_RUN;
                    st_d.erase = op_is_erase_i;
                    st_d.go    = 1'b1;
                end
            end
            PH_RUN: begin
                if (op_fail_i || op_done_i) st_d.ph = PH_IDLE;
                else if (susp_ack_i)        st_d.ph = PH_PAUSE;
            end
            PH_PAUSE: begin
                if (resume_i) st_d.ph = PH_RUN;
            end
            default: st_d.ph = PH_IDLE;
        endcase

        set_erase_fail_o = (run_fail && st_q.erase) || (vpp_bad && op_is_erase_i);
        set_prog_fail_o  = (run_fail && !st_q.erase) || (vpp_bad && !op_is_erase_i);
        set_vpp_o        = vpp_bad;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ph    <= PH_IDLE;
            st_q.erase <= 1'b0;
            st_q.go    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o     = st_q.ph;
    assign erase_o     = st_q.erase;
    assign engine_go_o = st_q.go;

    // a pause is only entered on an acknowledge
    assert_pause_needs_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_RUN && !susp_ack_i) |=> (st_q.ph != PH_PAUSE));

    // the engine is only launched by a start seen one cycle earlier
    assert_go_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.go |-> $past(op_start_i));

    // a refused start (errors pending) never leaves idle
    assert_refuse_with_errors_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && err_any_i) |=> (st_q.ph == PH_IDLE));
endmodule

// File: rtl/fsr_errbank.sv
module fsr_errbank
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_N-1:0] set_i,
    input  logic             clr_i,
    output logic [ERR_N-1:0] err_o
);
    typedef struct packed {
        logic [ERR_N-1:0] err;
    } eb_state_t;

    eb_state_t eb_d, eb_q;

    always_comb begin
        eb_d = eb_q;
        if (clr_i) eb_d.err = '0;
        eb_d.err = eb_d.err | set_i;   // a raise in the clear cycle survives
    end

    always_ff @(posedge clk) begin
        if (!rst_n) eb_q.err <= '0;
        else        eb_q     <= eb_d;
    end

    assign err_o = eb_q.err;

    // without a clear no flag ever drops
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((eb_q.err & $past(eb_q.err)) == $past(eb_q.err)));

    // a clear with nothing raised empties the bank
    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> (eb_q.err == '0));
endmodule

// File: rtl/fsr_snapshot.sv
module fsr_snapshot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe_n_i,
    input  logic [W-1:0] live_i,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         low;
        logic [W-1:0] snap;
    } sn_state_t;

    sn_state_t sn_d, sn_q;

    always_comb begin
        sn_d = sn_q;
        if (strobe_n_i) begin
            sn_d.low = 1'b0;
        end else if (!sn_q.low) begin
            sn_d.low  = 1'b1;
            sn_d.snap = live_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sn_q.low  <= 1'b0;
            sn_q.snap <= '0;
        end else begin
            sn_q <= sn_d;
        end
    end

    assign data_o = sn_q.low ? sn_q.snap : '0;

    // held while the strobe stays low
    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && sn_q.low) |=> (sn_q.snap == $past(sn_q.snap)));

    // falling edge takes the live word
    assert_snap_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && !sn_q.low) |=> (sn_q.snap == $past(live_i)));
endmodule

// File: rtl/pe_status_unit.sv
module pe_status_unit
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              op_is_erase,
    input  logic              vpp_ok,
    input  logic              op_done,
    input  logic              op_fail,
    input  logic              susp_ack,
    input  logic              resume,
    input  logic              lock_viol,
    input  logic              clr_status,
    input  logic              rd_strobe_n,
    output logic [STAT_W-1:0] rd_data,
    output logic              engine_go
);
    phase_e           phase;
    logic             run_erase;
    logic             set_efail, set_pfail, set_vpp;
    logic [ERR_N-1:0] err_set, err;
    logic [STAT_W-1:0] live;

    fsr_phase u_phase (
        .clk              (clk),
        .rst_n            (rst_n),
        .op_start_i       (op_start),
        .op_is_erase_i    (op_is_erase),
        .vpp_ok_i         (vpp_ok),
        .err_any_i        (|err),
        .op_done_i        (op_done),
        .op_fail_i        (op_fail),
        .susp_ack_i       (susp_ack),
        .resume_i         (resume),
        .phase_o          (phase),
        .erase_o          (run_erase),
        .engine_go_o      (engine_go),
        .set_erase_fail_o (set_efail),
        .set_prog_fail_o  (set_pfail),
        .set_vpp_o        (set_vpp)
    );

    always_comb begin
        err_set            = '0;
        err_set[ERR_ERASE] = set_efail;
        err_set[ERR_PROG]  = set_pfail;
        err_set[ERR_VPP]   = set_vpp;
        err_set[ERR_LOCK]  = lock_viol;
    end

    fsr_errbank u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (err_set),
        .clr_i (clr_status),
        .err_o (err)
    );

    always_comb begin
        live           = '0;
        live[SB_READY] = (phase != PH_RUN);
        live[SB_ESUSP] = (phase == PH_PAUSE) && run_erase;
        live[SB_PSUSP] = (phase == PH_PAUSE) && !run_erase;
        live[SB_EFAIL] = err[ERR_ERASE];
        live[SB_PFAIL] = err[ERR_PROG];
        live[SB_VPP]   = err[ERR_VPP];
        live[SB_LOCK]  = err[ERR_LOCK];
    end

    fsr_snapshot #(.W(STAT_W)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (rd_strobe_n),
        .live_i     (live),
        .data_o     (rd_data)
    );

    assert_bit0_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    // at most one pause flag, and a paused block reports ready
    assert_pause_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (live[SB_ESUSP] || live[SB_PSUSP]) |-> (!(live[SB_ESUSP] && live[SB_PSUSP]) && live[SB_READY]));
endmodule

// File: tb/tb_pe_status_unit.sv
`timescale 1ns/1ps
module tb_pe_status_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_is_erase = 0, vpp_ok = 1, op_done = 0, op_fail = 0;
    logic susp_ack = 0, resume = 0, lock_viol = 0, clr_status = 0, rd_strobe_n = 1;
    logic [7:0] rd_data;
    logic engine_go;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    pe_status_unit dut (
        .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
        .vpp_ok(vpp_ok), .op_done(op_done), .op_fail(op_fail), .susp_ack(susp_ack),
        .resume(resume), .lock_viol(lock_viol), .clr_status(clr_status),
        .rd_strobe_n(rd_strobe_n), .rd_data(rd_data), .engine_go(engine_go)
    );

    // behavioural reference: phase 0 idle, 1 running, 2 paused
    int        m_ph;
    bit        m_er;
    bit [3:0]  m_err;   // {erase fail, program fail, supply low, lock}
    bit        m_go;
    bit        m_low;
    bit [7:0]  m_snap;
    bit [7:0]  m_live;
    bit [3:0]  m_nerr;

    function automatic bit [7:0] model_word();
        bit [7:0] w = 8'h00;
        w[7] = (m_ph != 1);
        w[6] = (m_ph == 2) && m_er;
        w[2] = (m_ph == 2) && !m_er;
        w[5] = m_err[3];
        w[4] = m_err[2];
        w[3] = m_err[1];
        w[1] = m_err[0];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_er = 0; m_err = 0; m_go = 0; m_low = 0; m_snap = 0;
        end else begin
            m_live = model_word();
            if (rd_strobe_n) m_low = 0;
            else if (!m_low) begin m_low = 1; m_snap = m_live; end
            m_go = 0;
            m_nerr = clr_status ? 4'b0 : m_err;
            if (m_ph == 0) begin
                if (op_start && m_err == 0) begin
                    if (!vpp_ok) begin
                        m_nerr[1] = 1;
                        if (op_is_erase) m_nerr[3] = 1; else m_nerr[2] = 1;
                    end else begin
                        m_ph = 1; m_er = op_is_erase; m_go = 1;
                    end
                end
            end else if (m_ph == 1) begin
                if (op_fail) begin
                    if (m_er) m_nerr[3] = 1; else m_nerr[2] = 1;
                    m_ph = 0;
                end else if (op_done) m_ph = 0;
                else if (susp_ack) m_ph = 2;
            end else begin
                if (resume) m_ph = 1;
            end
            if (lock_viol) m_nerr[0] = 1;
            m_err = m_nerr;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (rd_data !== (m_low ? m_snap : 8'h00)) begin
                fails++;
                $display("FAIL R10 model read: actual %02h expected %02h", rd_data, m_low ? m_snap : 8'h00);
            end
            checks++;
            if (engine_go !== m_go) begin
                fails++;
                $display("FAIL R2 model engine_go: actual %0b expected %0b", engine_go, m_go);
            end
        end
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // event bits: 0 start,1 done,2 fail,3 pause ack,4 resume,5 lock,6 clear
    task automatic pulse(input logic [6:0] m, input logic er);
        op_start = m[0]; op_is_erase = er; op_done = m[1]; op_fail = m[2];
        susp_ack = m[3]; resume = m[4]; lock_viol = m[5]; clr_status = m[6];
        @(negedge clk);
        op_start = 0; op_done = 0; op_fail = 0; susp_ack = 0;
        resume = 0; lock_viol = 0; clr_status = 0;
    endtask

    task automatic read_word(input logic [7:0] exp, input string tag);
        rd_strobe_n = 0;
        @(negedge clk);
        check8(rd_data, exp, tag);
        check8({7'b0, rd_data[0]}, 8'h00, "R9 bit0");
        rd_strobe_n = 1;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check8({7'b0, engine_go}, 8'h00, "R1 engine_go idle");
        read_word(8'h80, "R1 reset word");

        // R2 program runs and completes
        pulse(7'b0000001, 1'b0);
        check8({7'b0, engine_go}, 8'h01, "R2 engine_go pulse");
        @(negedge clk);
        check8({7'b0, engine_go}, 8'h00, "R2 engine_go single cycle");
        read_word(8'h00, "R2 running");
        pulse(7'b0000001, 1'b1);               // start while running ignored
        read_word(8'h00, "R2 start ignored while running");
        pulse(7'b0000010, 1'b0);
        read_word(8'h80, "R2 done returns ready");

        // R3 pause ack while idle
        pulse(7'b0001000, 1'b0);
        read_word(8'h80, "R3 late pause ack ignored");

        // R3/R4/R5 erase paused, resumed, supply drops, fails
        pulse(7'b0000001, 1'b1);
        pulse(7'b0001000, 1'b0);
        read_word(8'hC0, "R3 erase paused");
        pulse(7'b0010000, 1'b0);
        read_word(8'h00, "R3 erase resumed");
        vpp_ok = 0;
        @(negedge clk);
        read_word(8'h00, "R5 supply change mid-run ignored");
        pulse(7'b0000100, 1'b0);
        vpp_ok = 1;
        read_word(8'hA0, "R4 erase failure sticky");
        pulse(7'b0000010, 1'b0);
        read_word(8'hA0, "R4 done does not clear");

        // R8 start refused with error pending
        pulse(7'b0000001, 1'b0);
        check8({7'b0, engine_go}, 8'h00, "R8 no engine_go");
        read_word(8'hA0, "R8 errors kept, idle");

        pulse(7'b1000000, 1'b0);
        read_word(8'h80, "R7 clear");

        // R5 low supply at start
        vpp_ok = 0;
        pulse(7'b0000001, 1'b0);
        check8({7'b0, engine_go}, 8'h00, "R5 no engine_go");
        vpp_ok = 1;
        read_word(8'h98, "R5 supply low program");
        pulse(7'b1000000, 1'b0);
        vpp_ok = 0;
        pulse(7'b0000001, 1'b1);
        vpp_ok = 1;
        read_word(8'hA8, "R5 supply low erase");
        pulse(7'b1000000, 1'b0);
        read_word(8'h80, "R7 clear after supply fault");

        // R6/R7 during a paused program
        pulse(7'b0000001, 1'b0);
        pulse(7'b0001000, 1'b0);
        read_word(8'h84, "R3 program paused");
        pulse(7'b1000000, 1'b0);
        read_word(8'h84, "R7 clear keeps pause bits");
        pulse(7'b0100000, 1'b0);
        read_word(8'h86, "R6 lock violation");
        pulse(7'b1100000, 1'b0);
        read_word(8'h86, "R7 raise wins over clear");
        pulse(7'b0010000, 1'b0);
        pulse(7'b0000010, 1'b0);
        read_word(8'h82, "R6 lock kept after done");
        pulse(7'b1000000, 1'b0);
        read_word(8'h80, "R7 lock cleared");

        // R10 snapshot held across a change
        pulse(7'b0000001, 1'b0);
        rd_strobe_n = 0;
        @(negedge clk);
        check8(rd_data, 8'h00, "R10 capture");
        pulse(7'b0000010, 1'b0);
        @(negedge clk);
        check8(rd_data, 8'h00, "R10 held while low");
        rd_strobe_n = 1;
        @(negedge clk);
        check8(rd_data, 8'h00, "R10 zero when strobe high");
        read_word(8'h80, "R10 fresh read");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule